// File: doc/BRIEF.md
# Bidirectional Program Counter Control

This block holds the control state of a processor that can run its program either forward or backward. The state has three parts: a program counter, a branch offset register and a one-bit direction flag that stands for +1 (forward) or −1 (backward). Branch-class instructions never write the program counter. They only add a direction-scaled offset into the branch register, negate it, flip the direction, or exchange it with a general register. On every enabled step the block applies that instruction effect first. It then moves the program counter by the branch register scaled by the direction, or by one step in the current direction when the branch register is zero.

The branch register keeps its value after a jump, so the step that led to the current state can always be found again. A pair of branches with opposite offsets acts as a jump and its landing pad. Flipping the direction and running the same code replays the steps exactly in reverse. The decoder ahead of the block supplies a 3-bit operation, a signed offset field, the equal and greater-than-zero comparison results, and the general register value used by the swap. Fetch, the data path and memory sit outside the block.

Top module: `rpc_ctrl`

## Requirements
- R1: After reset, the program counter, the branch register and the swap output are zero and the direction is forward (dir_bwd_o = 0).
- R2: On an enabled step that leaves the branch register at zero, the program counter moves by +1 when forward and by −1 when backward.
- R3: On an enabled step that leaves the branch register non-zero, the program counter moves by br when forward and by −br when backward. The branch register keeps its value through this update.
- R4: All program counter and branch register arithmetic wraps modulo 2^ADDR_W.
- R5: Operation 1 (unconditional jump) adds off·dir to the branch register.
- R6: Operation 2 adds off·dir only when eq_i is 1. Operation 3 adds it only when eq_i is 0. Operation 4 adds it only when gtz_i is 1. When its condition fails, the branch register is unchanged.
- R7: Operation 5 (reverse jump) sets the branch register to −(br + off·dir) and inverts the direction. No other operation changes the direction.
- R8: Operation 6 (swap) loads swap_in_i into the branch register, and swap_o takes the previous branch register value. swap_o changes on no other operation.
- R9: The instruction effect happens before the program counter update: the counter move in a step uses the branch register and direction that the same step produces.
- R10: While step_en_i is 0, the program counter, branch register, direction and swap output hold.
- R11: Operations 0 and 7 leave the branch register and direction unchanged; only the program counter update runs.
- R12: The offset field off_i is a two's-complement value of OFF_W bits and is sign-extended to ADDR_W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en_i | input | 1 | Advance one execution step this cycle |
| op_i | input | 3 | Branch-class operation code (0..7) |
| off_i | input | OFF_W | Signed branch offset |
| eq_i | input | 1 | The two compared registers are equal |
| gtz_i | input | 1 | The tested register is greater than zero |
| swap_in_i | input | ADDR_W | General register value loaded by a swap |
| pc_o | output | ADDR_W | Program counter |
| br_o | output | ADDR_W | Branch register |
| dir_bwd_o | output | 1 | Direction, 1 when backward |
| swap_o | output | ADDR_W | Branch register value swapped out |

## Verification
The bench builds the block with ADDR_W = 8 and OFF_W = 5. With those values, a jump of −9 from a low address wraps the counter past zero within a few steps. Both offset extremes (+15 and −16) can also be driven directly. A paired ±9 jump is run forward, the direction is flipped, and the pair is run backward to show that the control state returns exactly to where it started. After that, a long stream of random operations with random enables is compared against a behavioural model on every step.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_JMP  = 3'd1,
    OP_JEQ  = 3'd2,
    OP_JNE  = 3'd3,
    OP_JGZ  = 3'd4,
    OP_JREV = 3'd5,
    OP_SWAP = 3'd6,
    OP_RSV  = 3'd7
  } br_op_e;

endpackage

// File: rtl/rpc_cneg.sv
// Conditional two's-complement negation: multiply by +1 or -1 without a multiplier.
module rpc_cneg #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         neg_i,
  output logic [W-1:0] res_o
);

  always_comb begin
    if (neg_i) res_o = (~val_i) + {{(W-1){1'b0}}, 1'b1};
    else       res_o = val_i;
  end

endmodule

// File: rtl/rpc_branch_unit.sv
// Instruction effect on the branch register, direction flag and swap path.
module rpc_branch_unit
  import rpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [2:0]        op_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              eq_i,
  input  logic              gtz_i,
  input  logic [ADDR_W-1:0] swap_in_i,
  input  logic [ADDR_W-1:0] br_q_i,
  input  logic              dir_bwd_q_i,
  output logic [ADDR_W-1:0] br_d_o,
  output logic              dir_bwd_d_o,
  output logic              swap_load_o
);

  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] off_dir;
  logic [ADDR_W-1:0] br_sum;
  logic [ADDR_W-1:0] br_sum_neg;
  logic              take;
  br_op_e            op;

  assign op = br_op_e'(op_i);

  generate
    if (EXT_W > 0) begin : g_sext
      assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
    end else begin : g_trunc
      assign off_ext = off_i[ADDR_W-1:0];
    end
  endgenerate

  rpc_cneg #(.W(ADDR_W)) u_off_scale (
    .val_i (off_ext),
    .neg_i (dir_bwd_q_i),
    .res_o (off_dir)
  );

  assign br_sum = br_q_i + off_dir;

  rpc_cneg #(.W(ADDR_W)) u_rev_neg (
    .val_i (br_sum),
    .neg_i (1'b1),
    .res_o (br_sum_neg)
  );

  always_comb begin
    unique case (op)
      OP_JMP:  take = 1'b1;
      OP_JEQ:  take = eq_i;
      OP_JNE:  take = ~eq_i;
      OP_JGZ:  take = gtz_i;
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    br_d_o      = br_q_i;
    dir_bwd_d_o = dir_bwd_q_i;
    swap_load_o = 1'b0;
    case (op)
      OP_JMP, OP_JEQ, OP_JNE, OP_JGZ: begin
        if (take) br_d_o = br_sum;
      end
      OP_JREV: begin
        br_d_o      = br_sum_neg;
        dir_bwd_d_o = ~dir_bwd_q_i;
      end
      OP_SWAP: begin
        br_d_o      = swap_in_i;
        swap_load_o = 1'b1;
      end
      default: begin
        br_d_o = br_q_i;
      end
    endcase
  end

endmodule

// File: rtl/rpc_pc_step.sv
// Program counter update from the post-instruction branch register and direction.
module rpc_pc_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_q_i,
  input  logic [ADDR_W-1:0] br_d_i,
  input  logic              dir_bwd_d_i,
  output logic [ADDR_W-1:0] pc_d_o
);

  localparam logic [ADDR_W-1:0] UNIT = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] step_mag;
  logic [ADDR_W-1:0] step_signed;

  assign step_mag = (br_d_i == '0) ? UNIT : br_d_i;

  rpc_cneg #(.W(ADDR_W)) u_step_scale (
    .val_i (step_mag),
    .neg_i (dir_bwd_d_i),
    .res_o (step_signed)
  );

  assign pc_d_o = pc_q_i + step_signed;

endmodule

// File: rtl/rpc_ctrl.sv
module rpc_ctrl #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en_i,
  input  logic [2:0]        op_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              eq_i,
  input  logic              gtz_i,
  input  logic [ADDR_W-1:0] swap_in_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] br_o,
  output logic              dir_bwd_o,
  output logic [ADDR_W-1:0] swap_o
);

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] br_q, br_d;
  logic              dir_bwd_q, dir_bwd_d;
  logic [ADDR_W-1:0] swap_q, swap_d;
  logic              swap_load;

  rpc_branch_unit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_branch (
    .op_i        (op_i),
    .off_i       (off_i),
    .eq_i        (eq_i),
    .gtz_i       (gtz_i),
    .swap_in_i   (swap_in_i),
    .br_q_i      (br_q),
    .dir_bwd_q_i (dir_bwd_q),
    .br_d_o      (br_d),
    .dir_bwd_d_o (dir_bwd_d),
    .swap_load_o (swap_load)
  );

  rpc_pc_step #(.ADDR_W(ADDR_W)) u_pc_step (
    .pc_q_i      (pc_q),
    .br_d_i      (br_d),
    .dir_bwd_d_i (dir_bwd_d),
    .pc_d_o      (pc_d)
  );

  always_comb begin
    swap_d = swap_q;
    if (swap_load) swap_d = br_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= '0;
      br_q      <= '0;
      dir_bwd_q <= 1'b0;
      swap_q    <= '0;
    end else if (step_en_i) begin
      pc_q      <= pc_d;
      br_q      <= br_d;
      dir_bwd_q <= dir_bwd_d;
      swap_q    <= swap_d;
    end
  end

  assign pc_o      = pc_q;
  assign br_o      = br_q;
  assign dir_bwd_o = dir_bwd_q;
  assign swap_o    = swap_q;

endmodule

// File: rtl/rpc_ctrl_chk.sv
module rpc_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_en_i,
  input logic [2:0]        op_i,
  input logic [OFF_W-1:0]  off_i,
  input logic [ADDR_W-1:0] swap_in_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] br_o,
  input logic              dir_bwd_o,
  input logic [ADDR_W-1:0] swap_o
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en_i |=> ($stable(pc_o) && $stable(br_o) && $stable(dir_bwd_o) && $stable(swap_o))); // R10

  AST_DIR_ONLY_REV: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_i && op_i != 3'd5) |=> (dir_bwd_o == $past(dir_bwd_o))); // R7

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_i && op_i == 3'd0 && br_o == '0) |=>
      (pc_o == ($past(dir_bwd_o) ? ($past(pc_o) - ONE) : ($past(pc_o) + ONE)))); // R2

  AST_SWAP_XCHG: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_i && op_i == 3'd6) |=> (swap_o == $past(br_o) && br_o == $past(swap_in_i))); // R8

  AST_SWAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != 3'd6) |=> $stable(swap_o)); // R8

  AST_NOP_KEEPS_BR: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_i && (op_i == 3'd0 || op_i == 3'd7)) |=> (br_o == $past(br_o))); // R11

  AST_LONG_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_i && op_i == 3'd0 && br_o != '0) |=>
      (pc_o == ($past(dir_bwd_o) ? ($past(pc_o) - $past(br_o)) : ($past(pc_o) + $past(br_o))))); // R3

endmodule

bind rpc_ctrl rpc_ctrl_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_rpc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_en_i (step_en_i),
  .op_i      (op_i),
  .off_i     (off_i),
  .swap_in_i (swap_in_i),
  .pc_o      (pc_o),
  .br_o      (br_o),
  .dir_bwd_o (dir_bwd_o),
  .swap_o    (swap_o)
);

// File: tb/rpc_ctrl_bench.sv
module rpc_ctrl_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 8;
  localparam int OW = 5;
  localparam int MODV = 1 << AW;
  localparam int OMASK = (1 << OW) - 1;

  logic          clk;
  logic          rst_n;
  logic          step_en_i;
  logic [2:0]    op_i;
  logic [OW-1:0] off_i;
  logic          eq_i;
  logic          gtz_i;
  logic [AW-1:0] swap_in_i;
  logic [AW-1:0] pc_o;
  logic [AW-1:0] br_o;
  logic          dir_bwd_o;
  logic [AW-1:0] swap_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  int m_pc  = 0;
  int m_br  = 0;
  int m_dir = 1;
  int m_sw  = 0;

  rpc_ctrl #(.ADDR_W(AW), .OFF_W(OW)) u_rpc_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en_i (step_en_i),
    .op_i      (op_i),
    .off_i     (off_i),
    .eq_i      (eq_i),
    .gtz_i     (gtz_i),
    .swap_in_i (swap_in_i),
    .pc_o      (pc_o),
    .br_o      (br_o),
    .dir_bwd_o (dir_bwd_o),
    .swap_o    (swap_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int wrapm(input int x);
    return ((x % MODV) + MODV) % MODV;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(int'(pc_o) == m_pc, tag, "pc", int'(pc_o), m_pc);
    check(int'(br_o) == m_br, tag, "br", int'(br_o), m_br);
    check(dir_bwd_o == (m_dir < 0), tag, "dir_bwd", int'(dir_bwd_o), int'(m_dir < 0));
    check(int'(swap_o) == m_sw, tag, "swap", int'(swap_o), m_sw);
  endtask

  // One step: drive at negedge, model the cycle, sample at the next negedge.
  task automatic do_step(input bit en, input int op, input int off, input bit eq,
                         input bit gtz, input int swin, input string tag);
    int o, od, nbr, ndir, nsw, stp;
    bit take;
    step_en_i = en;
    op_i      = op[2:0];
    off_i     = off[OW-1:0];
    eq_i      = eq;
    gtz_i     = gtz;
    swap_in_i = swin[AW-1:0];
    if (en) begin
      o = off & OMASK;
      if (o >= (1 << (OW - 1))) o = o - (1 << OW);
      od = o * m_dir;
      take = (op == 1) || (op == 2 && eq) || (op == 3 && !eq) || (op == 4 && gtz);
      nbr = m_br; ndir = m_dir; nsw = m_sw;
      if (op >= 1 && op <= 4 && take) nbr = wrapm(m_br + od);
      if (op == 5) begin nbr = wrapm(-(m_br + od)); ndir = -m_dir; end
      if (op == 6) begin nsw = m_br; nbr = swin & (MODV - 1); end
      stp = (nbr == 0) ? ndir : nbr * ndir;
      m_pc = wrapm(m_pc + stp);
      m_br = nbr; m_dir = ndir; m_sw = nsw;
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    step_en_i = 1'b0; op_i = '0; off_i = '0; eq_i = 1'b0; gtz_i = 1'b0; swap_in_i = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    compare_all("R1");

    // R2: sequential forward stepping
    do_step(1, 0, 0, 0, 0, 0, "R2");
    do_step(1, 0, 0, 0, 0, 0, "R2");
    do_step(1, 0, 0, 0, 0, 0, "R2");

    // R7 paired jump, forward then reversed; R4 wrap below zero
    do_step(1, 1, -9, 0, 0, 0, "R4");
    do_step(1, 1, 9, 0, 0, 0, "R5");
    do_step(1, 5, 0, 0, 0, 0, "R7");
    do_step(1, 1, 9, 0, 0, 0, "R3");
    do_step(1, 1, -9, 0, 0, 0, "R5");
    do_step(1, 0, 0, 0, 0, 0, "R2");
    do_step(1, 5, 0, 0, 0, 0, "R7");
    // state should match the start of the paired jump shifted by one backward step
    check(int'(br_o) == 0 && dir_bwd_o == 1'b0, "R7", "restored br/dir",
          int'(br_o) + 1000 * int'(dir_bwd_o), 0);

    // R6 conditional variants
    do_step(1, 2, 4, 0, 0, 0, "R6");
    do_step(1, 2, 4, 1, 0, 0, "R9");
    do_step(1, 3, -4, 1, 0, 0, "R6");
    do_step(1, 3, -4, 0, 0, 0, "R6");
    do_step(1, 4, 3, 0, 0, 0, "R6");
    do_step(1, 4, 3, 0, 1, 0, "R6");
    do_step(1, 4, -3, 0, 1, 0, "R6");

    // R8 swap in and out, R10 hold
    do_step(1, 6, 0, 0, 0, 16, "R8");
    do_step(0, 6, 7, 1, 1, 99, "R10");
    do_step(0, 5, 7, 1, 1, 3, "R10");
    do_step(1, 6, 0, 0, 0, 0, "R8");

    // R11 reserved code, R12 offset extremes
    do_step(1, 7, 15, 1, 1, 55, "R11");
    do_step(1, 1, 15, 0, 0, 0, "R12");
    do_step(1, 1, -16, 0, 0, 0, "R12");
    do_step(1, 1, 1, 0, 0, 0, "R12");
    do_step(1, 5, 2, 0, 0, 0, "R7");
    do_step(1, 0, 0, 0, 0, 0, "R3");
    do_step(1, 5, -2, 0, 0, 0, "R7");

    // random stream against the model
    for (int i = 0; i < 400; i++) begin
      do_step($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 31),
              $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 255), "R9");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule